// File: doc/BRIEF.md
# Multi-Master System Bus Arbiter

This block decides, for one local processor, when to claim and when to give up a shared system bus that several masters use. It watches the processor's three status lines. A bus cycle starts when the status leaves the passive code. At that moment the block records whether the cycle needs the shared bus, and it clears that record when the status returns to passive. From that record and a set of strapping inputs, it requests the bus and seizes it. It later surrenders the bus when a higher-priority master, or a master using the common-request line, should get it.

Two clocks are involved. The processor clock times the status decoding and the address-enable output. The bus clock times every shared-bus signal. Crossings between the two clocks go through synchronizer chains of parameterized depth. The open-drain busy and common-request lines appear as drive enables, and the system resolves them as wired-AND lines with pull-ups. A single active-low initialize input clears every arbiter on the bus.

Top module: `mm_bus_arbiter`

## Requirements
- R1: Status 3'b111 is passive and ends any cycle. A cycle starts on the first non-passive status after passive. The halt code 3'b011 never needs the bus, and with both mode straps low every other code does.
- R2: With `iob_strap` high, a cycle needs the bus only when status bit 2 is 1 (memory). Codes 3'b000 (interrupt acknowledge), 3'b001 and 3'b010 cause no request.
- R3: With `resb_strap` high, a cycle needs the bus only if `sysb_sel` is high when the cycle starts. With the strap low, `sysb_sel` has no effect.
- R4: A cycle that needs the bus drives `breq_n` low. The bus is seized (`busy_drive` high) on a bus clock edge only when `bprn_n` is low and the busy line is high. `aen_n` is low only while the bus is owned.
- R5: If no surrender condition holds, the owner keeps the bus between cycles.
- R6: When `bprn_n` goes high while the bus is owned, the bus is surrendered only once no bus-needing cycle is in progress.
- R7: With `anyrq_strap` low, a low common-request line causes surrender only during a cycle that does not need the bus (halt, an IO cycle in IO-bus mode, or a resident cycle).
- R8: With `anyrq_strap` high, a low common-request line causes surrender whenever no bus-needing cycle is in progress. If the common-request line is held low, this gives up the bus after every transfer.
- R9: While `lock_n` is low, no surrender occurs.
- R10: While `crqlck_n` is low, the common-request line cannot cause surrender.
- R11: On surrender, `breq_n` goes high and `busy_drive` drops on the same bus clock edge.
- R12: `cbrq_drive` is high only while the block is requesting and does not own the bus. The owner never drives it.
- R13: While idle, `bpro_n` follows `bprn_n`. While requesting or owning, `bpro_n` is high.
- R14: While `init_n` is low, the block owns nothing: `breq_n` is high, `busy_drive` and `cbrq_drive` are low, and `aen_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| bclk | input | 1 | Shared bus clock |
| init_n | input | 1 | Active-low initialize, asynchronous |
| stat | input | 3 | Processor status code |
| lock_n | input | 1 | Active-low lock; blocks any surrender |
| crqlck_n | input | 1 | Active-low lock against common-request surrender |
| resb_strap | input | 1 | Resident-bus mode strap |
| iob_strap | input | 1 | IO-bus mode strap |
| anyrq_strap | input | 1 | Any-request strap |
| sysb_sel | input | 1 | System (high) / resident (low) select |
| bprn_n | input | 1 | Active-low priority in |
| busy_in | input | 1 | Resolved busy line level (low = bus taken) |
| cbrq_in | input | 1 | Resolved common-request line level |
| breq_n | output | 1 | Active-low bus request |
| bpro_n | output | 1 | Active-low priority out to the next arbiter |
| busy_drive | output | 1 | Pull busy line low when high |
| cbrq_drive | output | 1 | Pull common-request line low when high |
| aen_n | output | 1 | Active-low address enable (low = local drivers on) |

## Verification
A status change reaches the cycle record on the next processor clock edge. After that, it needs SYNC_STAGES bus clock edges to cross domains and one more edge to move the arbiter state. Ownership reaches `aen_n` SYNC_STAGES processor clock edges after it changes. A handover between two arbiters adds two more bus clock edges: one for the release and one for the seize. Each stimulus is therefore followed by 24 processor cycles, which is longer than the longest such chain, before any output is read. Inputs change and outputs are sampled 2 ns after a processor edge, a time that never coincides with a bus clock edge.

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       bclk,
  input  logic       init_n,
  input  logic [2:0] stat,
  input  logic       lock_n,
  input  logic       crqlck_n,
  input  logic       resb_strap,
  input  logic       iob_strap,
  input  logic       anyrq_strap,
  input  logic       sysb_sel,
  input  logic       bprn_n,
  input  logic       busy_in,
  input  logic       cbrq_in,
  output logic       breq_n,
  output logic       bpro_n,
  output logic       busy_drive,
  output logic       cbrq_drive,
  output logic       aen_n
);

  localparam logic [2:0] ST_PASSIVE = 3'b111;
  localparam logic [2:0] ST_HALT    = 3'b011;
  localparam logic [3:0] SYNC_RST   = 4'b1100;

  typedef enum logic [1:0] {ARB_IDLE, ARB_REQ, ARB_OWN} arb_t;

  logic [2:0]             stat_q;
  logic                   need_c, other_c, cyc_needs;
  logic [SYNC_STAGES-1:0] own_sync;
  logic [3:0]             bsync [SYNC_STAGES];
  logic                   lock_s, crq_s, need_s, other_s, give_up;
  arb_t                   st, st_nx;

  assign cyc_needs = (stat != ST_HALT) && (!iob_strap || stat[2]) && (!resb_strap || sysb_sel);

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      stat_q   <= ST_PASSIVE;
      need_c   <= 1'b0;
      other_c  <= 1'b0;
      own_sync <= '0;
    end else begin
      stat_q   <= stat;
      own_sync <= {own_sync[SYNC_STAGES-2:0], busy_drive};
      if (stat == ST_PASSIVE) begin
        need_c  <= 1'b0;
        other_c <= 1'b0;
      end else if (stat_q == ST_PASSIVE) begin
        need_c  <= cyc_needs;
        other_c <= !cyc_needs;
      end
    end
  end

  assign aen_n = ~own_sync[SYNC_STAGES-1];

  always_ff @(posedge bclk or negedge init_n) begin
    if (!init_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) bsync[i] <= SYNC_RST;
      st <= ARB_IDLE;
    end else begin
      bsync[0] <= {lock_n, crqlck_n, need_c, other_c};
      for (int i = 1; i < SYNC_STAGES; i++) bsync[i] <= bsync[i-1];
      st <= st_nx;
    end
  end

  assign {lock_s, crq_s, need_s, other_s} = bsync[SYNC_STAGES-1];

  assign give_up = lock_s &&
                   ((bprn_n && !need_s) ||
                    (!cbrq_in && crq_s && (anyrq_strap ? !need_s : other_s)));

  always_comb begin
    st_nx = st;
    case (st)
      ARB_IDLE: if (need_s) st_nx = ARB_REQ;
      ARB_REQ: begin
        if (!need_s)                st_nx = ARB_IDLE;
        else if (!bprn_n && busy_in) st_nx = ARB_OWN;
      end
      ARB_OWN:  if (give_up) st_nx = ARB_IDLE;
      default:  st_nx = ARB_IDLE;
    endcase
  end

  assign breq_n     = (st == ARB_IDLE);
  assign bpro_n     = (st == ARB_IDLE) ? bprn_n : 1'b1;
  assign busy_drive = (st == ARB_OWN);
  assign cbrq_drive = (st == ARB_REQ);

endmodule

// File: rtl/mm_bus_arbiter_chk.sv
module mm_bus_arbiter_chk (
  input logic bclk,
  input logic init_n,
  input logic bprn_n,
  input logic busy_in,
  input logic breq_n,
  input logic bpro_n,
  input logic busy_drive,
  input logic cbrq_drive,
  input logic lock_s,
  input logic need_s
);

  a_r4_seize_rule: assert property (@(posedge bclk) disable iff (!init_n)
    $rose(busy_drive) |-> ($past(busy_in) && !$past(bprn_n)));

  a_r6_hold_in_cycle: assert property (@(posedge bclk) disable iff (!init_n)
    (busy_drive && need_s) |=> busy_drive);

  a_r9_lock_hold: assert property (@(posedge bclk) disable iff (!init_n)
    (busy_drive && !lock_s) |=> busy_drive);

  a_r11_release: assert property (@(posedge bclk) disable iff (!init_n)
    $fell(busy_drive) |-> breq_n);

  a_r12_owner_quiet: assert property (@(posedge bclk) disable iff (!init_n)
    busy_drive |-> !cbrq_drive);

  a_r12_cbrq_with_req: assert property (@(posedge bclk) disable iff (!init_n)
    cbrq_drive |-> !breq_n);

  a_r13_bpro_block: assert property (@(posedge bclk) disable iff (!init_n)
    !breq_n |-> bpro_n);

endmodule

bind mm_bus_arbiter mm_bus_arbiter_chk u_chk (
  .bclk(bclk), .init_n(init_n), .bprn_n(bprn_n), .busy_in(busy_in),
  .breq_n(breq_n), .bpro_n(bpro_n), .busy_drive(busy_drive),
  .cbrq_drive(cbrq_drive), .lock_s(lock_s), .need_s(need_s)
);

// File: tb/mm_bus_arbiter_tb.sv
module mm_bus_arbiter_tb;

  logic clk = 1'b0, bclk = 1'b0, init_n = 1'b0;
  always #5 clk = ~clk;
  always #8 bclk = ~bclk;

  logic [2:0] stat_a = 3'b111, stat_b = 3'b111;
  logic lock_a = 1'b1, crq_a = 1'b1, resb_a = 1'b0, iob_a = 1'b0, any_a = 1'b0, sel_a = 1'b0;
  logic tie = 1'b0;
  logic breq_a, bpro_a, busy_a, cbrq_a, aen_a;
  logic breq_b, bpro_b, busy_b, cbrq_b, aen_b;
  logic busy_ln, cbrq_ln;

  assign busy_ln = ~(busy_a | busy_b);
  assign cbrq_ln = ~(cbrq_a | cbrq_b | tie);

  mm_bus_arbiter u_dut (
    .clk(clk), .bclk(bclk), .init_n(init_n), .stat(stat_a),
    .lock_n(lock_a), .crqlck_n(crq_a), .resb_strap(resb_a), .iob_strap(iob_a),
    .anyrq_strap(any_a), .sysb_sel(sel_a), .bprn_n(1'b0), .busy_in(busy_ln),
    .cbrq_in(cbrq_ln), .breq_n(breq_a), .bpro_n(bpro_a), .busy_drive(busy_a),
    .cbrq_drive(cbrq_a), .aen_n(aen_a));

  mm_bus_arbiter u_peer (
    .clk(clk), .bclk(bclk), .init_n(init_n), .stat(stat_b),
    .lock_n(1'b1), .crqlck_n(1'b1), .resb_strap(1'b0), .iob_strap(1'b0),
    .anyrq_strap(1'b0), .sysb_sel(1'b0), .bprn_n(bpro_a), .busy_in(busy_ln),
    .cbrq_in(cbrq_ln), .breq_n(breq_b), .bpro_n(bpro_b), .busy_drive(busy_b),
    .cbrq_drive(cbrq_b), .aen_n(aen_b));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // {stat_a, stat_b, lock_n, anyrq, tie, exp breq_a, exp aen_a, exp aen_b}
  localparam logic [11:0] VEC [17] = '{
    {3'b111, 3'b111, 3'b100, 3'b111},
    {3'b101, 3'b111, 3'b100, 3'b001},
    {3'b111, 3'b111, 3'b100, 3'b001},
    {3'b111, 3'b101, 3'b100, 3'b001},
    {3'b011, 3'b101, 3'b100, 3'b110},
    {3'b111, 3'b111, 3'b100, 3'b110},
    {3'b101, 3'b111, 3'b100, 3'b001},
    {3'b111, 3'b101, 3'b100, 3'b001},
    {3'b111, 3'b101, 3'b110, 3'b110},
    {3'b101, 3'b101, 3'b110, 3'b010},
    {3'b101, 3'b111, 3'b110, 3'b001},
    {3'b111, 3'b111, 3'b010, 3'b001},
    {3'b111, 3'b101, 3'b010, 3'b001},
    {3'b111, 3'b101, 3'b110, 3'b110},
    {3'b101, 3'b111, 3'b110, 3'b001},
    {3'b111, 3'b111, 3'b111, 3'b111},
    {3'b101, 3'b111, 3'b111, 3'b001}
  };
  string tags [17] = '{"R1", "R4", "R5", "R7", "R7", "R5", "R6", "R7", "R8",
                       "R6", "R6", "R9", "R9", "R9", "R4", "R8", "R8"};

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, got, exp);
    end
  endtask

  task automatic settle();
    repeat (24) @(posedge clk);
    #2;
  endtask

  task automatic do_init();
    @(posedge clk); #2;
    init_n = 1'b0;
    stat_a = 3'b111;
    stat_b = 3'b111;
    tie    = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    init_n = 1'b1;
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R14: state while init is held
    check("R14", "breq_a", breq_a, 1'b1);
    check("R14", "aen_a", aen_a, 1'b1);
    check("R14", "busy line", busy_ln, 1'b1);
    check("R14", "cbrq line", cbrq_ln, 1'b1);
    init_n = 1'b1;
    settle();
    check("R13", "bpro_a idle", bpro_a, 1'b0);

    for (int i = 0; i < 17; i++) begin
      stat_a = VEC[i][11:9];
      stat_b = VEC[i][8:6];
      lock_a = VEC[i][5];
      any_a  = VEC[i][4];
      tie    = VEC[i][3];
      settle();
      check(tags[i], "breq_a", breq_a, VEC[i][2]);
      check(tags[i], "aen_a", aen_a, VEC[i][1]);
      check(tags[i], "aen_b", aen_b, VEC[i][0]);
    end
    check("R13", "bpro_a owning", bpro_a, 1'b1);
    check("R12", "cbrq_a owning", cbrq_a, 1'b0);

    // R2: IO-bus mode
    lock_a = 1'b1; any_a = 1'b0;
    do_init();
    iob_a = 1'b1;
    stat_a = 3'b001; settle();
    check("R2", "breq_a io read", breq_a, 1'b1);
    stat_a = 3'b111; settle();
    stat_a = 3'b000; settle();
    check("R2", "breq_a int ack", breq_a, 1'b1);
    stat_a = 3'b111; settle();
    stat_a = 3'b101; settle();
    check("R2", "aen_a mem read", aen_a, 1'b0);

    // R3: resident-bus mode
    iob_a = 1'b0;
    do_init();
    resb_a = 1'b1; sel_a = 1'b0;
    stat_a = 3'b101; settle();
    check("R3", "breq_a resident", breq_a, 1'b1);
    stat_a = 3'b111; settle();
    sel_a = 1'b1;
    stat_a = 3'b101; settle();
    check("R3", "aen_a system", aen_a, 1'b0);
    resb_a = 1'b0; sel_a = 1'b0;
    stat_a = 3'b111; settle();
    stat_a = 3'b110; settle();
    check("R3", "aen_a strap low", aen_a, 1'b0);

    // R10: common-request lock
    do_init();
    iob_a = 1'b1; crq_a = 1'b0;
    stat_a = 3'b101; settle();
    stat_a = 3'b111; settle();
    stat_b = 3'b101; settle();
    stat_a = 3'b001; settle();
    check("R10", "aen_a held", aen_a, 1'b0);
    check("R12", "cbrq_b requesting", cbrq_b, 1'b1);
    crq_a = 1'b1; settle();
    check("R10", "aen_a released", aen_a, 1'b1);
    check("R7", "aen_b taken in io cycle", aen_b, 1'b0);
    check("R11", "breq_a after surrender", breq_a, 1'b1);

    // R14: init while the peer owns
    @(posedge clk); #2;
    init_n = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    check("R14", "aen_b during init", aen_b, 1'b1);
    check("R14", "busy line during init", busy_ln, 1'b1);
    check("R14", "breq_b during init", breq_b, 1'b1);
    init_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule